// File: doc/BRIEF.md
# CAM Match Priority Flag Generator

This block sits beside an associative (CAM) search array and turns each search into a two-wire, active-low match report. When a compare strobe arrives, it takes the array's hit flag and hit index, a 12-bit table index with a 4-bit page number, and a cascade input from higher-priority devices in the chain. It then decides the outcome of the search.

A CAM hit always wins. If the CAM misses, a direct-mapped table of single bits is consulted as a fallback. A stored 0 in that table means a match and a stored 1 means a mismatch. The table index is first ANDed with a configuration mask, so that short indices can be served from the low part of the table. The flags, address bus and page bus are registered and take their new values one clock after the strobe.

Table bits are set and cleared by separate commands, and they can be read back. These accesses always use the unmasked address. Because the fallback outcome (match-valid low, match-found high) is the same code that a device drives when a higher-priority device has hit, the pair of flags can be wired across a daisy chain and still mean the same thing everywhere.

Top module: `cam_prio_flags`

## Requirements
- R1: After reset, mv_n and mf_n are 1, addr_o and page_o are 0, and every table bit is 1 (mismatch), so a table read of any address returns 1.
- R2: On a compare with cas_hit_n=1 and cam_hit=1, one clock later mv_n=0, mf_n=0, addr_o equals cam_idx and page_o is 0, whatever the table holds.
- R3: On a compare with cas_hit_n=1, cam_hit=0 and a table bit of 0 at the looked-up index, one clock later mv_n=0, mf_n=1, addr_o is the masked index and page_o equals page_in.
- R4: On a compare with cas_hit_n=1, cam_hit=0 and a table bit of 1, one clock later mv_n=1, mf_n=1 and addr_o and page_o are 0. The code mv_n=1 with mf_n=0 never appears.
- R5: On a compare with cas_hit_n=0, one clock later mv_n=0, mf_n=1 and addr_o and page_o are 0. This holds even when cam_hit=1.
- R6: The compare lookup uses index & addr_mask. The mask is not applied to table set, clear or read accesses.
- R7: tbl_set writes 1 and tbl_clr writes 0 at tbl_addr. When both are asserted in the same cycle, the bit becomes 0.
- R8: With tbl_rd asserted, tbl_rdata shows the bit at the unmasked tbl_addr one clock later.
- R9: In a cycle without a compare, mv_n, mf_n, addr_o and page_o keep their values.
- R10: A compare and a table write to the same index in the same cycle: the compare sees the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp | input | 1 | Compare strobe |
| cam_hit | input | 1 | CAM search hit |
| cam_idx | input | 12 | CAM hit index |
| index | input | 12 | Table lookup index for the compare |
| page_in | input | 4 | Page number for the compare |
| cas_hit_n | input | 1 | Low when a higher-priority device hit in its CAM |
| addr_mask | input | 12 | Configuration mask ANDed with index |
| tbl_set | input | 1 | Write 1 (mismatch) at tbl_addr |
| tbl_clr | input | 1 | Write 0 (match) at tbl_addr |
| tbl_rd | input | 1 | Read the bit at tbl_addr |
| tbl_addr | input | 12 | Unmasked table access address |
| tbl_rdata | output | 1 | Registered table read data |
| mv_n | output | 1 | Match-valid, active low |
| mf_n | output | 1 | Match-found, active low |
| addr_o | output | 12 | CAM index or masked table index |
| page_o | output | 4 | Page number on a table match |

## Verification
Two functions can fall in the same cycle: a compare lookup and a table update (set and clear together, or one of them) at the same index. The bench provokes this by raising the compare strobe in the same cycle as a table write to the index the compare will look up. It judges the flags against the value the table held before that cycle. A later compare and a read then confirm that the write did take effect. The set/clear collision on one address is judged the same way, by reading the bit back.

// File: rtl/cam_prio_flags.sv
module cam_prio_flags #(
  parameter int AW = 12,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp,
  input  logic          cam_hit,
  input  logic [AW-1:0] cam_idx,
  input  logic [AW-1:0] index,
  input  logic [PW-1:0] page_in,
  input  logic          cas_hit_n,
  input  logic [AW-1:0] addr_mask,
  input  logic          tbl_set,
  input  logic          tbl_clr,
  input  logic          tbl_rd,
  input  logic [AW-1:0] tbl_addr,
  output logic          tbl_rdata,
  output logic          mv_n,
  output logic          mf_n,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] page_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] tbl;
  logic [AW-1:0]    look;
  logic             tbl_hit;

  assign look    = index & addr_mask;
  assign tbl_hit = ~tbl[look];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '1;
    end else begin
      if (tbl_set) tbl[tbl_addr] <= 1'b1;
      if (tbl_clr) tbl[tbl_addr] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_rdata <= 1'b1;
    else if (tbl_rd) tbl_rdata <= tbl[tbl_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_n   <= 1'b1;
      mf_n   <= 1'b1;
      addr_o <= '0;
      page_o <= '0;
    end else if (cmp) begin
      if (!cas_hit_n) begin
        {mv_n, mf_n} <= 2'b01;
        addr_o       <= '0;
        page_o       <= '0;
      end else if (cam_hit) begin
        {mv_n, mf_n} <= 2'b00;
        addr_o       <= cam_idx;
        page_o       <= '0;
      end else if (tbl_hit) begin
        {mv_n, mf_n} <= 2'b01;
        addr_o       <= look;
        page_o       <= page_in;
      end else begin
        {mv_n, mf_n} <= 2'b11;
        addr_o       <= '0;
        page_o       <= '0;
      end
    end
  end
endmodule

// File: rtl/cam_prio_flags_chk.sv
module cam_prio_flags_chk #(
  parameter int AW = 12,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp,
  input logic          cam_hit,
  input logic [AW-1:0] cam_idx,
  input logic [AW-1:0] index,
  input logic          cas_hit_n,
  input logic [AW-1:0] addr_mask,
  input logic          mv_n,
  input logic          mf_n,
  input logic [AW-1:0] addr_o,
  input logic [PW-1:0] page_o
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp |=> $stable({mv_n, mf_n, addr_o, page_o})); // R9
  AST_CAM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && cas_hit_n && cam_hit) |=> (!mv_n && !mf_n && addr_o == $past(cam_idx) && page_o == '0)); // R2
  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && !cas_hit_n) |=> (!mv_n && mf_n && addr_o == '0 && page_o == '0)); // R5
  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_n |-> !mv_n); // R4
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mv_n |-> (addr_o == '0 && page_o == '0)); // R4
  AST_MASKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && cas_hit_n && !cam_hit) |=> (mv_n || addr_o == ($past(index) & $past(addr_mask)))); // R6
endmodule

bind cam_prio_flags cam_prio_flags_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp(cmp), .cam_hit(cam_hit), .cam_idx(cam_idx),
  .index(index), .cas_hit_n(cas_hit_n), .addr_mask(addr_mask),
  .mv_n(mv_n), .mf_n(mf_n), .addr_o(addr_o), .page_o(page_o)
);

// File: tb/tb_cam_prio_flags.sv
module tb_cam_prio_flags;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmp = 0, cam_hit = 0, cas_hit_n = 1;
  logic [11:0] cam_idx = 0, index = 0, addr_mask = 12'hFFF, tbl_addr = 0;
  logic [3:0]  page_in = 0;
  logic        tbl_set = 0, tbl_clr = 0, tbl_rd = 0;
  logic        tbl_rdata, mv_n, mf_n;
  logic [11:0] addr_o;
  logic [3:0]  page_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cam_prio_flags dut (
    .clk(clk), .rst_n(rst_n), .cmp(cmp), .cam_hit(cam_hit), .cam_idx(cam_idx),
    .index(index), .page_in(page_in), .cas_hit_n(cas_hit_n), .addr_mask(addr_mask),
    .tbl_set(tbl_set), .tbl_clr(tbl_clr), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
    .tbl_rdata(tbl_rdata), .mv_n(mv_n), .mf_n(mf_n), .addr_o(addr_o), .page_o(page_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic mv, logic mf, logic [11:0] a, logic [3:0] p);
    chk(req, {mv_n, mf_n}, {mv, mf});
    chk(req, addr_o, a);
    chk(req, page_o, p);
  endtask

  task automatic do_cmp(logic hit, logic [11:0] ci, logic [11:0] ix, logic [3:0] pg, logic cn);
    @(negedge clk);
    cmp = 1; cam_hit = hit; cam_idx = ci; index = ix; page_in = pg; cas_hit_n = cn;
    @(negedge clk);
    cmp = 0; cam_hit = 0; cas_hit_n = 1;
  endtask

  task automatic tbl_op(logic s, logic c, logic [11:0] a);
    @(negedge clk);
    tbl_set = s; tbl_clr = c; tbl_addr = a;
    @(negedge clk);
    tbl_set = 0; tbl_clr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic v);
    @(negedge clk);
    tbl_rd = 1; tbl_addr = a;
    @(negedge clk);
    tbl_rd = 0;
    v = tbl_rdata;
  endtask

  task automatic t_reset;
    logic v;
    chk_out("R1", 1, 1, 0, 0);
    rd(12'h123, v); chk("R1 R8", v, 1);
  endtask

  task automatic t_miss;
    do_cmp(0, 0, 12'h345, 4'h3, 1);
    chk_out("R4", 1, 1, 0, 0);
  endtask

  task automatic t_table_match;
    logic v;
    tbl_op(0, 1, 12'h0AB);
    rd(12'h0AB, v); chk("R7 R8", v, 0);
    do_cmp(0, 0, 12'h0AB, 4'h5, 1);
    chk_out("R3", 0, 1, 12'h0AB, 4'h5);
  endtask

  task automatic t_mask;
    logic v;
    addr_mask = 12'h0FF;
    do_cmp(0, 0, 12'hFAB, 4'h9, 1);
    chk_out("R6", 0, 1, 12'h0AB, 4'h9);
    rd(12'hFAB, v); chk("R6 read unmasked", v, 1);
    addr_mask = 12'hFFF;
  endtask

  task automatic t_cam_priority;
    do_cmp(1, 12'h777, 12'h0AB, 4'h5, 1);
    chk_out("R2", 0, 0, 12'h777, 4'h0);
  endtask

  task automatic t_cascade;
    do_cmp(1, 12'h111, 12'h0AB, 4'h5, 0);
    chk_out("R5", 0, 1, 0, 0);
  endtask

  task automatic t_hold;
    do_cmp(0, 0, 12'h0AB, 4'h6, 1);
    @(negedge clk);
    cam_hit = 1; cam_idx = 12'hABC; index = 12'h555; page_in = 4'hF;
    repeat (3) @(negedge clk);
    cam_hit = 0;
    chk_out("R9", 0, 1, 12'h0AB, 4'h6);
  endtask

  task automatic t_set_clr;
    logic v;
    tbl_op(1, 0, 12'h0AB);
    rd(12'h0AB, v); chk("R7 set", v, 1);
    tbl_op(1, 1, 12'h0AB);
    rd(12'h0AB, v); chk("R7 clear wins", v, 0);
  endtask

  task automatic t_same_cycle;
    logic v;
    @(negedge clk);
    cmp = 1; cam_hit = 0; index = 12'h0AB; page_in = 4'h2; cas_hit_n = 1;
    tbl_set = 1; tbl_addr = 12'h0AB;
    @(negedge clk);
    cmp = 0; tbl_set = 0;
    chk_out("R10 old value", 0, 1, 12'h0AB, 4'h2);
    do_cmp(0, 0, 12'h0AB, 4'h2, 1);
    chk_out("R10 after write", 1, 1, 0, 0);
    rd(12'h0AB, v); chk("R10 written", v, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_miss;
    t_table_match;
    t_mask;
    t_cam_priority;
    t_cascade;
    t_hold;
    t_set_clr;
    t_same_cycle;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule